// File: doc/BRIEF.md
# Setup-Masked Memory Window Register

This block holds a 32-bit memory base address register that a host programs through its configuration port. How much of the register the host may change is not fixed in hardware. A size setup value, loaded earlier over a local load port, decides which address bits are writable and whether the window is advertised as prefetchable. In a full design that local port is driven by a serial ROM loader or a local processor. A lockout flag is set at reset and keeps the host out until the local side has loaded the setup value and released the lock.

Once the window has been placed, the block decodes memory addresses. An address that falls inside the window is classified in one of two ways. If it lies in the first 4 KB of the window, it is reported as an access to the internal control/status registers, together with its offset. If it lies in the rest of the window, it is reported as traffic to be forwarded downstream. Decoding is registered and is enabled by a memory-enable input.

Top module: `mem_bar_window`

## Requirements
- R1: After reset the lockout is active, `cfg_rdata` reads 0 and both hit outputs are low. With no setup loaded, the window is 4 KB and nonprefetchable.
- R2: While lockout is active, host writes (`cfg_wr`) are discarded and `cfg_rdata` reads 0. A one-cycle pulse on `ld_unlock` clears the lockout, and only a reset sets it again.
- R3: Once unlocked, `cfg_rdata` bit 0, bits 2:1 and bits 11:4 always read 0. This means a memory window that may sit anywhere in the 32-bit space.
- R4: `cfg_rdata` bit 3 is read-only. It returns bit 3 of the most recent local load, where 1 means prefetchable.
- R5: For each register bit n in 30:12, the bit is writable when bit n of the loaded setup value is 1 and then returns the last value written. When setup bit n is 0, the register bit reads 0.
- R6: Register bit 31 is writable for every setup value, which gives a maximum window of 2 GB.
- R7: When setup bits 30:12 are all 0, the window is 4 KB: every bit in 31:12 is writable and no address is ever flagged for forwarding.
- R8: An address hits when it equals the register on every writable bit. For a hit, the outputs change one clock after the address is presented. If the address bits in 31:12 that are not writable are all 0, `csr_hit` is set and `csr_offset` carries address bits 11:0. Otherwise `fwd_hit` is set.
- R9: When `mem_en` or `addr_valid` is low in a cycle, both hit outputs are low in the following cycle.
- R10: `csr_hit` and `fwd_hit` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load the setup value from ld_data |
| ld_data | input | 32 | Setup value: bits 31:12 size mask, bit 3 prefetchable |
| ld_unlock | input | 1 | Clear the host lockout |
| cfg_wr | input | 1 | Host write strobe to the base register |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read value of the base register |
| mem_en | input | 1 | Memory decode enable |
| addr_valid | input | 1 | Address strobe |
| addr | input | 32 | Memory address to decode |
| csr_hit | output | 1 | Registered: address is in the low 4 KB of the window |
| csr_offset | output | 12 | Registered: byte offset into the register space |
| fwd_hit | output | 1 | Registered: address is in the window above 4 KB |

## Verification
The assertions assume a few things about the inputs. Reset is asserted before the first decode. The address and enable inputs are stable across the sampling edge. Lockout is only ever released, never re-armed, except by a reset. The stimulus honours all of this: it changes inputs only just after a rising edge and pulses `ld_unlock` exactly once after reset. Its random phase sometimes derives addresses from the reference model's current base value, so that the region inside the window and both sides of the 4 KB boundary are actually reached.

// File: rtl/bar_win_pkg.sv
package bar_win_pkg;

   // classification of one decoded address
   typedef enum logic [1:0] {
      HIT_NONE = 2'b00,
      HIT_CSR  = 2'b01,
      HIT_FWD  = 2'b10
   } hit_kind_e;

   // classify given match and whether the window offset stays below the register page
   function automatic hit_kind_e classify(input logic match, input logic in_page);
      if (!match)
         return HIT_NONE;
      else if (in_page)
         return HIT_CSR;
      else
         return HIT_FWD;
   endfunction

endpackage

// File: rtl/bar_setup_reg.sv
module bar_setup_reg #(
   parameter int AW       = 32,
   parameter int CSR_AW   = 12,
   parameter int PREF_BIT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_valid,
   input  logic [AW-1:0] ld_data,
   input  logic          ld_unlock,
   output logic [AW-1:0] win_mask,
   output logic          pref,
   output logic          lock
);
   localparam int SZ_W = AW - CSR_AW;

   logic [SZ_W-1:0] size_q;
   logic            pref_q;
   logic            lock_q;
   logic            min_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         pref_q <= 1'b0;
         lock_q <= 1'b1;
      end else begin
         if (ld_valid) begin
            size_q <= ld_data[AW-1:CSR_AW];
            pref_q <= ld_data[PREF_BIT];
         end
         if (ld_unlock)
            lock_q <= 1'b0;
      end
   end

   // no size bit below the top set: smallest window, every page bit decodes
   assign min_win = (size_q[SZ_W-2:0] == '0);

   for (genvar i = 0; i < AW; i++) begin : g_mask
      if (i < CSR_AW) begin : g_page
         assign win_mask[i] = 1'b0;
      end else if (i == AW - 1) begin : g_top
         assign win_mask[i] = 1'b1;
      end else begin : g_size
         assign win_mask[i] = size_q[i-CSR_AW] | min_win;
      end
   end

   assign pref = pref_q;
   assign lock = lock_q;

endmodule

// File: rtl/bar_base_reg.sv
module bar_base_reg #(
   parameter int AW       = 32,
   parameter int CSR_AW   = 12,
   parameter int PREF_BIT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          lock,
   input  logic [AW-1:0] win_mask,
   input  logic          pref,
   output logic [AW-1:0] base,
   output logic [AW-1:0] rdata
);
   logic          wr_ok;
   logic [AW-1:0] view;

   assign wr_ok = cfg_wr & ~lock;

   for (genvar i = 0; i < AW; i++) begin : g_bit
      if (i >= CSR_AW) begin : g_addr
         logic b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               b_q <= 1'b0;
            else if (wr_ok)
               b_q <= cfg_wdata[i] & win_mask[i];
         end
         // re-mask so a narrowed setup reads back zero at once
         assign base[i] = b_q & win_mask[i];
         assign view[i] = base[i];
      end else if (i == PREF_BIT) begin : g_pref
         assign base[i] = 1'b0;
         assign view[i] = pref;
      end else begin : g_zero
         assign base[i] = 1'b0;
         assign view[i] = 1'b0;
      end
   end

   assign rdata = lock ? '0 : view;

endmodule

// File: rtl/bar_decode.sv
module bar_decode
   import bar_win_pkg::*;
#(
   parameter int AW     = 32,
   parameter int CSR_AW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_en,
   input  logic              addr_valid,
   input  logic [AW-1:0]     addr,
   input  logic [AW-1:0]     base,
   input  logic [AW-1:0]     win_mask,
   output logic              csr_hit,
   output logic              fwd_hit,
   output logic [CSR_AW-1:0] csr_offset
);
   logic          match;
   logic          in_page;
   logic [AW-1:0] outside;
   hit_kind_e     kind_d;
   hit_kind_e     kind_q;
   logic [CSR_AW-1:0] off_q;

   assign match   = (((addr ^ base) & win_mask) == '0);
   assign outside = addr & ~win_mask;
   assign in_page = (outside[AW-1:CSR_AW] == '0);

   always_comb begin
      if (mem_en && addr_valid)
         kind_d = classify(match, in_page);
      else
         kind_d = HIT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= HIT_NONE;
         off_q  <= '0;
      end else begin
         kind_q <= kind_d;
         off_q  <= (kind_d == HIT_CSR) ? addr[CSR_AW-1:0] : '0;
      end
   end

   assign csr_hit    = (kind_q == HIT_CSR);
   assign fwd_hit    = (kind_q == HIT_FWD);
   assign csr_offset = off_q;

endmodule

// File: rtl/mem_bar_window.sv
module mem_bar_window #(
   parameter int AW       = 32,
   parameter int CSR_AW   = 12,
   parameter int PREF_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [AW-1:0]     ld_data,
   input  logic              ld_unlock,
   input  logic              cfg_wr,
   input  logic [AW-1:0]     cfg_wdata,
   output logic [AW-1:0]     cfg_rdata,
   input  logic              mem_en,
   input  logic              addr_valid,
   input  logic [AW-1:0]     addr,
   output logic              csr_hit,
   output logic [CSR_AW-1:0] csr_offset,
   output logic              fwd_hit
);
   if (AW < CSR_AW + 2) begin : g_bad_aw
      $error("mem_bar_window: AW must exceed CSR_AW by at least two");
   end
   if (PREF_BIT >= CSR_AW || PREF_BIT < 3) begin : g_bad_pref
      $error("mem_bar_window: PREF_BIT must sit in the read-only low field above bit 2");
   end

   logic [AW-1:0] win_mask;
   logic [AW-1:0] base;
   logic          pref;
   logic          lock;

   bar_setup_reg #(.AW(AW), .CSR_AW(CSR_AW), .PREF_BIT(PREF_BIT)) u_setup (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_valid (ld_valid),
      .ld_data  (ld_data),
      .ld_unlock(ld_unlock),
      .win_mask (win_mask),
      .pref     (pref),
      .lock     (lock)
   );

   bar_base_reg #(.AW(AW), .CSR_AW(CSR_AW), .PREF_BIT(PREF_BIT)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_wdata(cfg_wdata),
      .lock     (lock),
      .win_mask (win_mask),
      .pref     (pref),
      .base     (base),
      .rdata    (cfg_rdata)
   );

   bar_decode #(.AW(AW), .CSR_AW(CSR_AW)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_en    (mem_en),
      .addr_valid(addr_valid),
      .addr      (addr),
      .base      (base),
      .win_mask  (win_mask),
      .csr_hit   (csr_hit),
      .fwd_hit   (fwd_hit),
      .csr_offset(csr_offset)
   );

endmodule

// File: rtl/mem_bar_window_chk.sv
module mem_bar_window_chk #(
   parameter int AW     = 32,
   parameter int CSR_AW = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_en,
   input logic              addr_valid,
   input logic [AW-1:0]     addr,
   input logic              cfg_wr,
   input logic [AW-1:0]     cfg_rdata,
   input logic              csr_hit,
   input logic              fwd_hit,
   input logic [CSR_AW-1:0] csr_offset,
   input logic              lock,
   input logic [AW-1:0]     base
);
   // R10
   excl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_hit && fwd_hit));

   // R9
   idle_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_en && addr_valid) |=> !(csr_hit || fwd_hit));

   // R2
   locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |-> (cfg_rdata == '0));

   // R2
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && cfg_wr) |=> $stable(base));

   // R2
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |=> !lock);

   // R3
   low_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[2:0] == 3'b000) && (cfg_rdata[CSR_AW-1:4] == '0));

   // R8
   offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && addr_valid) |=> (!csr_hit || (csr_offset == $past(addr[CSR_AW-1:0]))));

endmodule

bind mem_bar_window mem_bar_window_chk #(.AW(AW), .CSR_AW(CSR_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_en    (mem_en),
   .addr_valid(addr_valid),
   .addr      (addr),
   .cfg_wr    (cfg_wr),
   .cfg_rdata (cfg_rdata),
   .csr_hit   (csr_hit),
   .fwd_hit   (fwd_hit),
   .csr_offset(csr_offset),
   .lock      (lock),
   .base      (base)
);

// File: tb/test_mem_bar_window.sv
`timescale 1ns/1ps
module test_mem_bar_window;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0;
   logic [31:0] ld_data = '0;
   logic        ld_unlock = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_en = 1'b0;
   logic        addr_valid = 1'b0;
   logic [31:0] addr = '0;
   logic        csr_hit;
   logic [11:0] csr_offset;
   logic        fwd_hit;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state
   logic [31:0] m_setup = '0;
   logic [31:0] m_base  = '0;
   logic        m_lock  = 1'b1;
   logic        e_csr = 1'b0, e_fwd = 1'b0;
   logic [11:0] e_off = '0;

   always #2.5 clk = ~clk;

   mem_bar_window i_mem_bar_window (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
      .ld_unlock(ld_unlock), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .mem_en(mem_en), .addr_valid(addr_valid),
      .addr(addr), .csr_hit(csr_hit), .csr_offset(csr_offset), .fwd_hit(fwd_hit)
   );

   function automatic logic [31:0] eff_mask(input logic [31:0] s);
      logic [31:0] m;
      m = s & 32'h7FFF_F000;
      if (m == 0) return 32'hFFFF_F000;
      return m | 32'h8000_0000;
   endfunction

   function automatic logic [31:0] model_read();
      if (m_lock) return 32'h0;
      return (m_base & eff_mask(m_setup)) | {28'h0, m_setup[3], 3'b000};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: predict, advance, compare
   task automatic cyc();
      logic [31:0] m;
      logic        n_csr, n_fwd;
      logic [11:0] n_off;
      m = eff_mask(m_setup);
      n_csr = 1'b0; n_fwd = 1'b0; n_off = '0;
      if (rst_n && mem_en && addr_valid && (((addr ^ m_base) & m) == 0)) begin
         if ((addr & ~m & 32'hFFFF_F000) == 0) begin
            n_csr = 1'b1; n_off = addr[11:0];
         end else begin
            n_fwd = 1'b1;
         end
      end
      @(posedge clk);
      if (!rst_n) begin
         m_setup = '0; m_base = '0; m_lock = 1'b1;
         e_csr = 1'b0; e_fwd = 1'b0; e_off = '0;
      end else begin
         if (cfg_wr && !m_lock) m_base = cfg_wdata & m;
         if (ld_valid) m_setup = ld_data;
         if (ld_unlock) m_lock = 1'b0;
         e_csr = n_csr; e_fwd = n_fwd; e_off = n_off;
      end
      #1;
      check("R5 cfg_rdata", cfg_rdata, model_read());
      check("R8 decode", {19'h0, csr_hit, fwd_hit, csr_offset}, {19'h0, e_csr, e_fwd, e_off});
   endtask

   task automatic host_wr(input logic [31:0] d);
      cfg_wr = 1'b1; cfg_wdata = d; cyc(); cfg_wr = 1'b0;
   endtask

   task automatic load(input logic [31:0] d);
      ld_valid = 1'b1; ld_data = d; cyc(); ld_valid = 1'b0;
   endtask

   task automatic probe(input logic en, input logic v, input logic [31:0] a);
      mem_en = en; addr_valid = v; addr = a; cyc(); addr_valid = 1'b0;
   endtask

   initial begin
      repeat (2) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      check("R1 rdata", cfg_rdata, 32'h0);
      check("R1 hits", {31'h0, csr_hit | fwd_hit}, 32'h0);
      // R2 locked write dropped, read zero
      host_wr(32'hFFFF_FFFF);
      check("R2 locked read", cfg_rdata, 32'h0);
      ld_unlock = 1'b1; cyc(); ld_unlock = 1'b0;
      check("R2 write was dropped", cfg_rdata, 32'h0);
      // R7 minimum window
      host_wr(32'hFFFF_FFFF);
      check("R7 4KB window", cfg_rdata, 32'hFFFF_F000);
      check("R3 low field", {20'h0, cfg_rdata[11:0]}, 32'h0);
      probe(1'b1, 1'b1, 32'hFFFF_F123);
      check("R8 csr hit", {19'h0, csr_hit, fwd_hit, csr_offset}, {19'h0, 1'b1, 1'b0, 12'h123});
      probe(1'b1, 1'b1, 32'hFFFF_E123);
      check("R7 no forward", {31'h0, fwd_hit | csr_hit}, 32'h0);
      // R4 R5 1 MB prefetchable window
      load(32'hFFF0_0008);
      host_wr(32'hFFFF_FFFF);
      check("R4 prefetch bit", {31'h0, cfg_rdata[3]}, 32'h1);
      check("R5 1MB mask", cfg_rdata, 32'hFFF0_0008);
      host_wr(32'h1234_5678);
      check("R5 readback", cfg_rdata, 32'h1230_0008);
      probe(1'b1, 1'b1, 32'h1230_0ABC);
      check("R8 csr offset", {19'h0, csr_hit, fwd_hit, csr_offset}, {19'h0, 1'b1, 1'b0, 12'hABC});
      probe(1'b1, 1'b1, 32'h1234_5678);
      check("R8 forward", {30'h0, csr_hit, fwd_hit}, 32'h1);
      check("R10 exclusive", {31'h0, csr_hit & fwd_hit}, 32'h0);
      probe(1'b1, 1'b1, 32'h1240_0000);
      check("R8 miss", {30'h0, csr_hit, fwd_hit}, 32'h0);
      probe(1'b0, 1'b1, 32'h1234_5678);
      check("R9 mem_en low", {30'h0, csr_hit, fwd_hit}, 32'h0);
      probe(1'b1, 1'b0, 32'h1230_0010);
      check("R9 valid low", {30'h0, csr_hit, fwd_hit}, 32'h0);
      // R6 top bit always writable
      load(32'h4000_0000);
      host_wr(32'hFFFF_FFFF);
      check("R6 bit31 writable", cfg_rdata, 32'hC000_0000);
      load(32'h0000_0000);
      check("R7 back to 4KB", cfg_rdata, 32'hC000_0000);
      // random phase, compared every clock
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r;
         r = $urandom;
         cfg_wr = (r[2:0] == 3'd0);
         cfg_wdata = $urandom;
         ld_valid = (r[6:3] == 4'd0);
         ld_data = $urandom;
         mem_en = (r[9:7] != 3'd0);
         addr_valid = (r[11:10] != 2'd0);
         if (r[12]) addr = m_base ^ {11'h0, r[20:13], 13'h0} ^ {20'h0, r[31:20]};
         else addr = $urandom;
         cyc();
      end
      cfg_wr = 1'b0; ld_valid = 1'b0; addr_valid = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule